// File: doc/BRIEF.md
# Programmable Symmetric Decimating FIR Filter

This block is a time-multiplexed FIR filter for linear-phase coefficient sets. It keeps a shift-register history of input samples and a bank of half-length coefficients. One multiply-accumulate unit walks the folded tap pairs of each output: it pre-adds or pre-subtracts the two samples that share a coefficient, multiplies the sum by that coefficient and accumulates the product. The filter length, the decimation ratio, the symmetry sense and a mode that zeroes one pre-adder input are set in one 16-bit control word. A bypass setting replaces the whole configuration with a fixed pass-through arrangement.

Software writes the control word through a small strobed write port and loads coefficients through a separate indexed write port. Samples arrive with a valid strobe. One result leaves for every D accepted samples, marked by a single-cycle valid pulse. A busy flag covers the multiply-accumulate pass, and new samples are held off while it is high.

Top module: `fir_decim_sym`

## Requirements
- R1: The control word is written from `cfg_data_i` only when `cfg_wr_i` and `cfg_cs_i` are both high and `cfg_addr_i` is 0. Any write that lacks a strobe, or that targets another address, leaves the filter's behaviour unchanged. Field positions: bit 15 zero-pre-adder, bit 14 bypass, bit 13 even symmetry, bits 12:9 decimation-minus-one, bits 8:0 length-minus-one.
- R2: The filter length N is the length field plus 1, clamped to the range 3 to MAX_TAPS. With x[0] the newest accepted sample and c[k] the coefficient at index k, the result is the sum over k from 0 to ceil(N/2)-1 of c[k]·(x[k] ± x[N-1-k]). When N is odd, the centre term k=(N-1)/2 uses x[k] alone.
- R3: Symmetry bit 13 = 1 makes the pre-adder add x[k]+x[N-1-k]. Bit 13 = 0 makes it subtract: x[k]−x[N-1-k].
- R4: Zero-pre-adder bit 15 = 1 forces the paired input to zero, so every term is c[k]·x[k].
- R5: With decimation field D−1 in 0..15, exactly one result is computed for every D accepted samples, on the D-th one. The other samples raise neither `busy_o` nor `res_valid_o`.
- R6: With bypass bit 14 = 1, every accepted sample produces a result. That result carries the sample's DW bits on `res_data_o[DW-1:0]` with all upper bits zero, whatever the other fields and the stored coefficients are.
- R7: A control write that clears bypass marks the coefficients invalid. Results are still computed (`busy_o` pulses), but `res_valid_o` stays low until a coefficient write, made outside bypass, targets index ceil(N/2)−1.
- R8: After the sample that starts a computation is accepted, `busy_o` is high for exactly ceil(N/2) cycles. `res_valid_o` then pulses for one cycle, in the cycle in which `busy_o` has returned low, and `res_data_o` holds the result.
- R9: A sample presented while `busy_o` is high is discarded. It enters neither the history nor the decimation count.
- R10: Reset clears the control word, the sample history, the coefficients, the accumulator and the outputs, and marks the coefficients valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Control write strobe |
| cfg_cs_i | input | 1 | Control select |
| cfg_addr_i | input | 2 | Control register address (only 0 is implemented) |
| cfg_data_i | input | 16 | Control word |
| coef_wr_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | $clog2((MAX_TAPS+1)/2) | Coefficient index k |
| coef_data_i | input | CW | Signed coefficient |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_data_i | input | DW | Signed input sample |
| busy_o | output | 1 | Multiply-accumulate pass in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | DW+CW+1+$clog2((MAX_TAPS+1)/2) | Signed result |

## Verification
The last step of a multiply-accumulate pass and the arrival of the next input sample can fall on the same clock edge. On that edge the result strobe is being raised while `busy_o` is still high. The bench provokes this case by holding the sample strobe high for many consecutive cycles with a new value each cycle. A 4-tap filter is used, so only every third value can be taken. The bench judges the run by comparing the number and the values of the results against a model that keeps only those values in its history, which shows that the sample on the completion edge was dropped and the following one was kept.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int CFG_W = 16;

  // field order mirrors the control word bit layout (msb first)
  typedef struct packed {
    logic       zpa;
    logic       byp;
    logic       even;
    logic [3:0] drate;
    logic [8:0] taps;
  } cfg_word_t;
endpackage

// File: rtl/fir_cfg_regs.sv
module fir_cfg_regs
  import fir_pkg::*;
#(
  parameter int MAX_TAPS = 32,
  parameter int CNT_W    = 6,
  parameter int AW       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             cs_i,
  input  logic [1:0]       addr_i,
  input  logic [CFG_W-1:0] data_i,
  input  logic             coef_wr_i,
  input  logic [AW-1:0]    coef_addr_i,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W-1:0] pairs_o,
  output logic [3:0]       drate_o,
  output logic             even_o,
  output logic             zpa_o,
  output logic             byp_o,
  output logic             coef_ok_o
);
  cfg_word_t        cfg_q, cfg_new;
  logic             coef_ok_q;
  logic             wr_hit;
  logic [9:0]       n_raw;
  logic [CNT_W-1:0] nb_n, nb_pairs;

  assign cfg_new = cfg_word_t'(data_i);
  assign wr_hit  = wr_i && cs_i && (addr_i == 2'd0);
  assign n_raw   = {1'b0, cfg_q.taps} + 10'd1;

  always_comb begin
    if (n_raw < 10'd3)                nb_n = CNT_W'(3);
    else if (n_raw > 10'(MAX_TAPS))   nb_n = CNT_W'(MAX_TAPS);
    else                              nb_n = CNT_W'(n_raw);
  end
  assign nb_pairs = (nb_n + CNT_W'(1)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      coef_ok_q <= 1'b1;
    end else begin
      if (wr_hit) cfg_q <= cfg_new;
      if (wr_hit && cfg_q.byp && !cfg_new.byp)
        coef_ok_q <= 1'b0;
      else if (coef_wr_i && !cfg_q.byp && (coef_addr_i == AW'(nb_pairs - CNT_W'(1))))
        coef_ok_q <= 1'b1;
    end
  end

  // bypass: fixed 3-tap even pass-through, no decimation
  assign n_o       = cfg_q.byp ? CNT_W'(3) : nb_n;
  assign pairs_o   = cfg_q.byp ? CNT_W'(2) : nb_pairs;
  assign drate_o   = cfg_q.byp ? 4'd0 : cfg_q.drate;
  assign even_o    = cfg_q.byp | cfg_q.even;
  assign zpa_o     = cfg_q.byp | cfg_q.zpa;
  assign byp_o     = cfg_q.byp;
  assign coef_ok_o = coef_ok_q;
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int NP = 16,
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [CW-1:0] rdata_o
);
  logic [CW-1:0] mem_q [NP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) mem_q[i] <= '0;
    end else if (wr_i && (int'(waddr_i) < NP)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < NP) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       shift_i,
  input  logic [DW-1:0]              din_i,
  output logic [DEPTH-1:0][DW-1:0]   taps_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DW-1:0] src;
    if (g == 0) begin : g_head
      assign src = din_i;
    end else begin : g_body
      assign src = taps_o[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      taps_o[g] <= '0;
      else if (shift_i) taps_o[g] <= src;
    end
  end
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq #(
  parameter int MAX_TAPS = 32,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int ACC_W    = 37,
  parameter int CNT_W    = 6,
  parameter int AW       = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     en_i,
  input  logic [CNT_W-1:0]         n_i,
  input  logic [CNT_W-1:0]         pairs_i,
  input  logic                     even_i,
  input  logic                     zpa_i,
  input  logic                     byp_i,
  input  logic [MAX_TAPS-1:0][DW-1:0] taps_i,
  input  logic [CW-1:0]            coef_i,
  output logic [AW-1:0]            coef_addr_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [ACC_W-1:0]         res_o
);
  localparam int IW = $clog2(MAX_TAPS);
  localparam int PW = DW + 1;
  localparam int MW = PW + CW;

  logic [AW-1:0]           step_q;
  logic                    busy_q, done_q, last;
  logic signed [ACC_W-1:0] acc_q, acc_nxt;
  logic [ACC_W-1:0]        res_q;
  logic [IW-1:0]           idx_a, idx_b;
  logic signed [PW-1:0]    xa, xb, pre;
  logic signed [CW-1:0]    c_eff;
  logic signed [MW-1:0]    prod;

  assign idx_a = IW'(step_q);
  assign idx_b = IW'(n_i - CNT_W'(1) - CNT_W'(step_q));
  assign xa    = PW'($signed(taps_i[idx_a]));
  assign xb    = PW'($signed(taps_i[idx_b]));

  always_comb begin
    if (zpa_i || (idx_a == idx_b)) pre = xa;
    else if (even_i)               pre = xa + xb;
    else                           pre = xa - xb;
  end

  // bypass uses a unit coefficient on the newest sample only
  assign c_eff   = byp_i ? ((step_q == '0) ? CW'(1) : '0) : $signed(coef_i);
  assign prod    = pre * c_eff;
  assign acc_nxt = acc_q + {{(ACC_W-MW){prod[MW-1]}}, prod};
  assign last    = (step_q == AW'(pairs_i - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        step_q <= '0;
        acc_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= en_i;
          acc_q  <= '0;
          res_q  <= byp_i ? ACC_W'(acc_nxt[DW-1:0]) : acc_nxt;
        end else begin
          acc_q  <= acc_nxt;
          step_q <= step_q + AW'(1);
        end
      end
    end
  end

  assign coef_addr_o = step_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign res_o       = res_q;
endmodule

// File: rtl/fir_decim_sym.sv
module fir_decim_sym
  import fir_pkg::*;
#(
  parameter int MAX_TAPS = 32,
  parameter int DW       = 16,
  parameter int CW       = 16,
  localparam int NP      = (MAX_TAPS + 1) / 2,
  localparam int AW      = (NP > 1) ? $clog2(NP) : 1,
  localparam int ACC_W   = DW + CW + 1 + AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_cs_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             coef_wr_i,
  input  logic [AW-1:0]    coef_addr_i,
  input  logic [CW-1:0]    coef_data_i,
  input  logic             smp_valid_i,
  input  logic [DW-1:0]    smp_data_i,
  output logic             busy_o,
  output logic             res_valid_o,
  output logic [ACC_W-1:0] res_data_o
);
  localparam int CNT_W = $clog2(MAX_TAPS + 2);

  logic [CNT_W-1:0]            n, pairs;
  logic [3:0]                  drate, dcnt_q;
  logic                        even, zpa, byp, coef_ok;
  logic                        busy, accept, grp_end, start;
  logic [MAX_TAPS-1:0][DW-1:0] taps;
  logic [AW-1:0]               coef_raddr;
  logic [CW-1:0]               coef_rdata;

  fir_cfg_regs #(.MAX_TAPS(MAX_TAPS), .CNT_W(CNT_W), .AW(AW)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i(cfg_wr_i), .cs_i(cfg_cs_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .coef_wr_i, .coef_addr_i,
    .n_o(n), .pairs_o(pairs), .drate_o(drate),
    .even_o(even), .zpa_o(zpa), .byp_o(byp), .coef_ok_o(coef_ok)
  );

  fir_coef_store #(.NP(NP), .CW(CW), .AW(AW)) u_coef (
    .clk_i, .rst_ni,
    .wr_i(coef_wr_i), .waddr_i(coef_addr_i), .wdata_i(coef_data_i),
    .raddr_i(coef_raddr), .rdata_o(coef_rdata)
  );

  // samples offered during a MAC pass are dropped
  assign accept  = smp_valid_i && !busy;
  assign grp_end = (dcnt_q >= drate);
  assign start   = accept && grp_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dcnt_q <= '0;
    else if (accept) dcnt_q <= grp_end ? 4'd0 : dcnt_q + 4'd1;
  end

  fir_delay_line #(.DEPTH(MAX_TAPS), .DW(DW)) u_dly (
    .clk_i, .rst_ni, .shift_i(accept), .din_i(smp_data_i), .taps_o(taps)
  );

  fir_mac_seq #(
    .MAX_TAPS(MAX_TAPS), .DW(DW), .CW(CW), .ACC_W(ACC_W), .CNT_W(CNT_W), .AW(AW)
  ) u_mac (
    .clk_i, .rst_ni,
    .start_i(start), .en_i(coef_ok | byp),
    .n_i(n), .pairs_i(pairs), .even_i(even), .zpa_i(zpa), .byp_i(byp),
    .taps_i(taps), .coef_i(coef_rdata), .coef_addr_o(coef_raddr),
    .busy_o(busy), .done_o(res_valid_o), .res_o(res_data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/fir_decim_sym_chk.sv
module fir_decim_sym_chk #(
  parameter int MAX_TAPS = 32,
  parameter int DW       = 16,
  parameter int ACC_W    = 37
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic             busy_o,
  input logic             res_valid_o,
  input logic [ACC_W-1:0] res_data_o,
  input logic             byp_i,
  input logic             coef_ok_i
);
  localparam int NP = (MAX_TAPS + 1) / 2;
  logic [$clog2(MAX_TAPS+2)-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (!busy_o && $past(busy_o)));                                 // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);                                               // R8
  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(run_q) < NP));                                              // R8
  AST_BUSY_FROM_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(smp_valid_i));                                       // R5
  AST_BYP_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(byp_i)) |-> (res_data_o[ACC_W-1:DW] == '0));           // R6
  AST_COEF_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(coef_ok_i || byp_i));                                  // R7
endmodule

bind fir_decim_sym fir_decim_sym_chk #(.MAX_TAPS(MAX_TAPS), .DW(DW), .ACC_W(ACC_W)) u_chk (
  .clk_i, .rst_ni, .smp_valid_i, .busy_o, .res_valid_o, .res_data_o,
  .byp_i(byp), .coef_ok_i(coef_ok)
);

// File: tb/tb_fir_decim_sym.sv
`timescale 1ns/1ps
module tb_fir_decim_sym;
  localparam int MAX_TAPS = 32;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int AW = 4;
  localparam int ACC_W = DW + CW + 1 + AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_ni = 1'b0;
  logic             cfg_wr = 0, cfg_cs = 0;
  logic [1:0]       cfg_addr = '0;
  logic [15:0]      cfg_data = '0;
  logic             coef_wr = 0;
  logic [AW-1:0]    coef_addr = '0;
  logic [CW-1:0]    coef_data = '0;
  logic             smp_valid = 0;
  logic [DW-1:0]    smp_data = '0;
  logic             busy, res_valid;
  logic [ACC_W-1:0] res_data;

  fir_decim_sym dut (
    .clk_i(clk), .rst_ni, .cfg_wr_i(cfg_wr), .cfg_cs_i(cfg_cs), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .coef_wr_i(coef_wr), .coef_addr_i(coef_addr),
    .coef_data_i(coef_data), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .busy_o(busy), .res_valid_o(res_valid), .res_data_o(res_data)
  );

  int errors = 0, checks = 0;
  int hist[MAX_TAPS];
  int coefs[16];
  logic [15:0] b_word;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  function automatic int taps_now();
    int n;
    if (b_word[14]) return 3;
    n = int'(b_word[8:0]) + 1;
    if (n < 3) n = 3;
    if (n > MAX_TAPS) n = MAX_TAPS;
    return n;
  endfunction

  function automatic longint ref_y();
    int n; bit ev, zp, by; longint s, pre, c;
    by = b_word[14];
    n  = taps_now();
    ev = by | b_word[13];
    zp = by | b_word[15];
    s  = 0;
    for (int k = 0; k < (n + 1) / 2; k++) begin
      if (zp || (k == n - 1 - k)) pre = hist[k];
      else if (ev)                pre = hist[k] + hist[n-1-k];
      else                        pre = hist[k] - hist[n-1-k];
      c = by ? ((k == 0) ? 1 : 0) : coefs[k];
      s += pre * c;
    end
    if (by) s = s & 64'hFFFF;
    return s;
  endfunction

  function automatic longint got();
    return longint'($signed(res_data));
  endfunction

  task automatic push(input logic [15:0] v);
    for (int i = MAX_TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = int'($signed(v));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; cfg_wr = 0; cfg_cs = 0; coef_wr = 0; smp_valid = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    for (int i = 0; i < MAX_TAPS; i++) hist[i] = 0;
    for (int i = 0; i < 16; i++) coefs[i] = 0;
    b_word = '0;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d, input bit we, input bit cs);
    cfg_addr = a; cfg_data = d; cfg_wr = we; cfg_cs = cs;
    @(negedge clk);
    cfg_wr = 0; cfg_cs = 0;
    if (we && cs && a == 2'd0) b_word = d;
  endtask

  task automatic coef_write(input int a, input int v);
    coef_addr = AW'(a); coef_data = CW'(v); coef_wr = 1;
    @(negedge clk);
    coef_wr = 0;
    coefs[a] = int'($signed(CW'(v)));
  endtask

  // non-final sample of a decimation group
  task automatic feed(input logic [15:0] v, input string tag);
    smp_data = v; smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
    push(v);
    chk(!busy && !res_valid, tag, {busy, res_valid}, 0);
  endtask

  task automatic sample(input logic [15:0] v, output bit seen, output longint val,
                        output int lat, output bit busy0);
    smp_data = v; smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
    push(v);
    busy0 = busy; seen = 0; val = 0; lat = 0;
    for (int i = 0; i < 40; i++) begin
      if (res_valid) begin seen = 1; val = got(); break; end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(input logic [15:0] v, input string tag);
    bit seen, b0; longint val, e; int lat;
    sample(v, seen, val, lat, b0);
    e = ref_y();
    chk(seen && val == e, tag, val, e);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!busy && !res_valid && res_data == '0, "R10 reset outputs", longint'(res_data), 0);
    cfg_write(2'd0, 16'h2003, 1, 1);
    run_one(16'd7, "R10 cleared history and coefficients");
  endtask

  task automatic t_even();
    bit seen, b0; longint val, e; int lat;
    do_reset();
    cfg_write(2'd0, 16'h2003, 1, 1);
    coef_write(0, 2); coef_write(1, 3);
    run_one(16'd1, "R2 even N=4 s1");
    run_one(16'd2, "R2 even N=4 s2");
    run_one(16'd3, "R3 even add s3");
    sample(16'd4, seen, val, lat, b0);
    e = ref_y();
    chk(seen && val == 25, "R2 even N=4 sum", val, 25);
    chk(b0 == 1, "R8 busy after accept", b0, 1);
    chk(lat == 2, "R8 latency pairs", lat, 2);
    run_one(16'hFFF0, "R2 negative sample");
  endtask

  task automatic t_odd_len();
    do_reset();
    cfg_write(2'd0, 16'h2004, 1, 1);
    coef_write(0, 1); coef_write(1, 10); coef_write(2, 100);
    for (int i = 1; i <= 4; i++) run_one(16'(i), "R2 odd length fill");
    run_one(16'd5, "R2 centre tap alone");
    chk(ref_y() == 366, "R2 centre model", ref_y(), 366);
    cfg_write(2'd0, 16'h0004, 1, 1);
    run_one(16'd9, "R3 odd symmetry subtract");
    cfg_write(2'd0, 16'hA004, 1, 1);
    run_one(16'd11, "R4 zero pre-adder");
  endtask

  task automatic t_decim();
    do_reset();
    cfg_write(2'd0, 16'h2403, 1, 1);
    coef_write(0, 5); coef_write(1, -3);
    for (int g = 0; g < 2; g++) begin
      feed(16'(g * 10 + 1), "R5 decim 3 no output");
      feed(16'(g * 10 + 2), "R5 decim 3 no output");
      run_one(16'(g * 10 + 3), "R5 decim 3 result");
    end
    cfg_write(2'd0, 16'h3E03, 1, 1);
    for (int i = 0; i < 15; i++) feed(16'(100 + i), "R5 decim 16 no output");
    run_one(16'd200, "R5 decim 16 result");
  endtask

  task automatic t_bypass();
    bit seen, b0; longint val; int lat;
    do_reset();
    coef_write(0, 77); coef_write(1, 9);
    cfg_write(2'd0, 16'h5E07, 1, 1);
    run_one(16'h1234, "R6 bypass pass-through");
    sample(16'h8001, seen, val, lat, b0);
    chk(seen && val == 32769, "R6 bypass low bits upper zero", val, 32769);
    run_one(16'h0042, "R6 bypass ignores decimation");
  endtask

  task automatic t_reload();
    bit seen, b0; longint val; int lat;
    do_reset();
    cfg_write(2'd0, 16'h2003, 1, 1);
    coef_write(0, 4); coef_write(1, 6);
    cfg_write(2'd0, 16'h4000, 1, 1);
    run_one(16'd3, "R6 bypass before reload test");
    cfg_write(2'd0, 16'h2003, 1, 1);
    sample(16'd8, seen, val, lat, b0);
    chk(!seen, "R7 no valid after leaving bypass", seen, 0);
    chk(b0 == 1, "R7 still computes", b0, 1);
    coef_write(0, 4);
    sample(16'd9, seen, val, lat, b0);
    chk(!seen, "R7 index 0 not enough", seen, 0);
    coef_write(1, 6);
    run_one(16'd10, "R7 valid after last index reload");
  endtask

  task automatic t_wr_gate();
    do_reset();
    cfg_write(2'd0, 16'h2003, 1, 1);
    coef_write(0, 2); coef_write(1, 3);
    cfg_write(2'd0, 16'h4000, 1, 0);
    run_one(16'd5, "R1 no cs ignored");
    cfg_write(2'd0, 16'h4000, 0, 1);
    run_one(16'd6, "R1 no write strobe ignored");
    cfg_write(2'd1, 16'h4000, 1, 1);
    run_one(16'd7, "R1 other address ignored");
  endtask

  task automatic t_busy_drop();
    longint exp_v[3], got_v[3]; int np;
    do_reset();
    cfg_write(2'd0, 16'h2003, 1, 1);
    coef_write(0, 2); coef_write(1, -5);
    np = 0;
    for (int i = 0; i < 9; i++) begin
      smp_data = 16'(10 + i); smp_valid = 1;
      @(negedge clk);
      if (i % 3 == 0) begin push(16'(10 + i)); exp_v[i/3] = ref_y(); end
      if (res_valid) begin if (np < 3) got_v[np] = got(); np++; end
    end
    smp_valid = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (res_valid) begin if (np < 3) got_v[np] = got(); np++; end
    end
    chk(np == 3, "R9 pulses while stream held", np, 3);
    for (int j = 0; j < 3; j++)
      if (j < np) chk(got_v[j] == exp_v[j], "R9 busy-edge sample dropped", got_v[j], exp_v[j]);
  endtask

  task automatic t_max();
    bit seen, b0; longint val, e; int lat;
    do_reset();
    cfg_write(2'd0, 16'h201F, 1, 1);
    for (int k = 0; k < 16; k++) coef_write(k, k + 1);
    for (int i = 0; i < 31; i++) run_one(16'(i * 3 - 20), "R2 max length fill");
    sample(16'd500, seen, val, lat, b0);
    e = ref_y();
    chk(seen && val == e, "R2 max length result", val, e);
    chk(lat == 16, "R8 latency max length", lat, 16);
    cfg_write(2'd0, 16'h2064, 1, 1);
    run_one(16'd321, "R2 length clamp");
  endtask

  initial begin
    t_reset();
    t_even();
    t_odd_len();
    t_decim();
    t_bypass();
    t_reload();
    t_wr_gate();
    t_busy_drop();
    t_max();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule